// File: doc/BRIEF.md
# Subcarrier Frequency and Phase-Reset Controller

This block drives the colour subcarrier oscillator of a video encoder. It produces two things: a 22-bit frequency word and a one-cycle phase-reset request. One shared input pin feeds it, and a two-bit mode field sets how that pin is read.

In real-time-control mode, the pin carries a framed serial stream from an external video decoder. Each bit of the stream lasts two pixel clocks. The block finds the start of each frame and takes in the frame's 67 data bits. It keeps only bits 0 to 21, which hold the compensated subcarrier increment. When a frame is complete, the new increment becomes the frequency word at the next line-start strobe, so the oscillator follows line-length variation one line at a time.

In subcarrier-reset mode, a rising edge on the pin does not act at once. It arms a request, and the request is issued at the next field-start strobe. In the two remaining mode codes, the pin is ignored and the frequency word is taken from the programmed register value.

Top module: `subcarrier_ctl`

## Requirements
- R1: During and right after reset, `phase_reset` is 0 and the loaded serial word is 0, so `freq_word` reads 0 in real-time-control mode.
- R2: With `pin_mode` 2'b00 or 2'b11, `freq_word` equals `prog_freq`. The pin never causes `phase_reset`, and a serial frame sent in these modes does not change the loaded word.
- R3: Frame start is a rising edge on `sc_pin` after at least GAP_CLKS consecutive low cycles. A two-clock start bit follows, then 67 data bits of two clocks each. Each data bit is sampled on the second clock of its period.
- R4: Data bit 0 is the first data bit after the start bit and becomes the LSB of the word. Data bits 0 to 21 form the word, and data bits 22 to 66 have no effect.
- R5: A received word reaches `freq_word` only at the first `line_start` strobe after its frame is complete. Before that strobe the previous word is held, and a strobe with no new frame leaves the word unchanged.
- R6: With `pin_mode` 2'b10 (real-time control), `freq_word` is the loaded serial word, whatever the value of `prog_freq`.
- R7: With `pin_mode` 2'b01 (subcarrier reset), a rising edge on `sc_pin` does not pulse `phase_reset` at once. `phase_reset` is high for exactly the one cycle after the next sampled `field_start`.
- R8: A rising edge that arrives while a reset is already pending schedules no second reset.
- R9: A rising edge sampled in the same cycle as `field_start` is served at the following field start, not the current one.
- R10: A pending reset is dropped when the mode leaves 2'b01. In real-time-control mode, the pin never causes `phase_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_mode | input | 2 | 00/11 pin unused, 01 subcarrier reset, 10 real-time control |
| sc_pin | input | 1 | Shared reset-trigger / serial-stream pin |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| prog_freq | input | 22 | Programmed subcarrier frequency word |
| freq_word | output | 22 | Frequency word to the oscillator |
| phase_reset | output | 1 | One-cycle request to reset subcarrier phase to field 0 |

## Verification
Several frames run through the serial path. Their low 22 bits hold alternating, walking-one, all-ones and all-zero patterns, and their upper bits are set in contrasting ways. This shows the bit order, the use of only the 22-bit slice, and that the unused bits are ignored. Each frame is checked both before and after its line strobe, which separates arrival of a frame from its application.

The reset path is tried with:
- a single edge;
- repeated edges before one field start;
- an edge coinciding with a field start;
- an edge followed by a mode change.

Together these show that the reset is deferred, counted only once, and dropped correctly.

// File: rtl/sc_pkg.sv
// Package: shared mode encoding for the subcarrier controller.
// Assumes the two-bit mode field is decoded only by subcarrier_ctl.
package sc_pkg;
    typedef enum logic [1:0] {
        PIN_IDLE   = 2'b00,
        PIN_SCRST  = 2'b01,
        PIN_RTC    = 2'b10,
        PIN_IDLE_B = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/sc_serial_rx.sv
// Module: deserializes one framed serial stream from the shared pin.
// It keeps the first WORD_W data bits, LSB first, and flags the end of
// each frame. Assumes the pin is already synchronous to clk.
module sc_serial_rx #(
    parameter int WORD_W     = 22,
    parameter int FRAME_BITS = 67,
    parameter int CLK_PER_BIT = 2,
    parameter int GAP_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pin_now,
    input  logic              pin_prev,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    localparam int BIDX_W = $clog2(FRAME_BITS + 1);
    localparam int PH_W   = $clog2(CLK_PER_BIT + 1);
    localparam int GAP_W  = $clog2(GAP_CLKS + 1);

    typedef enum logic {RX_WAIT, RX_BUSY} rx_state_e;

    rx_state_e          state;
    logic [BIDX_W-1:0]  bidx;
    logic [PH_W-1:0]    ph;
    logic [GAP_W-1:0]   lowcnt;
    logic               start_hit;

    assign start_hit = pin_now && !pin_prev && (lowcnt == GAP_W'(GAP_CLKS));

    // Purpose: count consecutive low cycles on the pin, saturating at the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || state == RX_BUSY || pin_now) begin
            lowcnt <= '0;
        end else if (lowcnt != GAP_W'(GAP_CLKS)) begin
            lowcnt <= lowcnt + 1'b1;
        end
    end

    // Purpose: frame sequencer that times bit periods and samples data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state  <= RX_WAIT;
            bidx   <= '0;
            ph     <= '0;
            done_o <= 1'b0;
            if (!rst_n) word_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (state == RX_WAIT) begin
                if (start_hit) begin
                    state <= RX_BUSY;
                    bidx  <= '0;
                    ph    <= PH_W'(1);
                end
            end else if (ph == PH_W'(CLK_PER_BIT - 1)) begin
                ph <= '0;
                if (bidx != '0 && bidx <= BIDX_W'(WORD_W)) begin
                    word_o <= {pin_now, word_o[WORD_W-1:1]};
                end
                if (bidx == BIDX_W'(FRAME_BITS)) begin
                    done_o <= 1'b1;
                    state  <= RX_WAIT;
                end else begin
                    bidx <= bidx + 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state == RX_BUSY)); // R3
endmodule

// File: rtl/sc_word_hold.sv
// Module: holds a received word until the next line start, then makes it
// the active word. Assumes new_valid is a one-cycle pulse.
module sc_word_hold #(
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] new_word,
    input  logic              new_valid,
    input  logic              line_start,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] pend_word;
    logic              pend_valid;

    // Purpose: park a fresh word and apply the parked one at a line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_word  <= '0;
            pend_valid <= 1'b0;
            word_o     <= '0;
        end else begin
            if (line_start && pend_valid) begin
                word_o <= pend_word;
            end
            if (new_valid) begin
                pend_word  <= new_word;
                pend_valid <= 1'b1;
            end else if (line_start) begin
                pend_valid <= 1'b0;
            end
        end
    end

    AST_APPLY_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> $past(line_start)); // R5
    AST_PEND_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid) |-> $past(new_valid)); // R5
endmodule

// File: rtl/sc_reset_sched.sv
// Module: arms a phase-reset request on a pin rising edge and issues it as
// a one-cycle pulse after the next field start. Assumes field_start is a
// one-cycle strobe.
module sc_reset_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rise,
    input  logic field_start,
    output logic phase_rst_o
);
    logic pend;

    // Purpose: track one pending request and fire it at a field start.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pend        <= 1'b0;
            phase_rst_o <= 1'b0;
        end else begin
            phase_rst_o <= field_start && pend;
            if (field_start) begin
                pend <= rise;
            end else if (rise) begin
                pend <= 1'b1;
            end
        end
    end

    AST_PULSE_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst_o |-> $past(field_start)); // R7
endmodule

// File: rtl/subcarrier_ctl.sv
// Module: top of the subcarrier controller. It decodes the pin mode and
// routes the shared pin to the serial loader or to the reset scheduler.
// It also selects the frequency word. Assumes sc_pin is synchronous to clk.
module subcarrier_ctl
    import sc_pkg::*;
#(
    parameter int FREQ_W      = 22,
    parameter int FRAME_BITS  = 67,
    parameter int CLK_PER_BIT = 2,
    parameter int GAP_CLKS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pin_mode,
    input  logic              sc_pin,
    input  logic              line_start,
    input  logic              field_start,
    input  logic [FREQ_W-1:0] prog_freq,
    output logic [FREQ_W-1:0] freq_word,
    output logic              phase_reset
);
    pin_mode_e         mode;
    logic              pin_q;
    logic              rtc_on;
    logic              scr_on;
    logic [FREQ_W-1:0] rx_word;
    logic              rx_done;
    logic [FREQ_W-1:0] rtc_word;

    assign mode   = pin_mode_e'(pin_mode);
    assign rtc_on = (mode == PIN_RTC);
    assign scr_on = (mode == PIN_SCRST);

    // Purpose: keep the previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= sc_pin;
    end

    sc_serial_rx #(
        .WORD_W(FREQ_W), .FRAME_BITS(FRAME_BITS),
        .CLK_PER_BIT(CLK_PER_BIT), .GAP_CLKS(GAP_CLKS)
    ) i_rx (
        .clk(clk), .rst_n(rst_n), .en(rtc_on),
        .pin_now(sc_pin), .pin_prev(pin_q),
        .word_o(rx_word), .done_o(rx_done)
    );

    sc_word_hold #(.WORD_W(FREQ_W)) i_hold (
        .clk(clk), .rst_n(rst_n),
        .new_word(rx_word), .new_valid(rx_done),
        .line_start(line_start), .word_o(rtc_word)
    );

    sc_reset_sched i_sched (
        .clk(clk), .rst_n(rst_n), .en(scr_on),
        .rise(sc_pin && !pin_q), .field_start(field_start),
        .phase_rst_o(phase_reset)
    );

    // Purpose: pick the oscillator word for the current pin mode.
    always_comb begin
        freq_word = rtc_on ? rtc_word : prog_freq;
    end

    AST_RST_ONLY_IN_SCR: assert property (@(posedge clk) disable iff (!rst_n)
        phase_reset |-> $past(pin_mode) == 2'b01); // R10
    AST_NO_LOAD_OUTSIDE_RTC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pin_mode) != 2'b10 |-> $stable(rtc_word)); // R2
endmodule

// File: tb/test_subcarrier_ctl.sv
module test_subcarrier_ctl;
    localparam int W = 22;
    localparam int NF = 67;
    localparam int NV = 5;
    // Table: full frames, bit k sent as the k-th data bit.
    localparam logic [NF-1:0] FRAMES [NV] = '{
        {45'h0, 22'h2AAAAA},
        {45'h1FFFFFFFFFFF, 22'h155555},
        {45'h155555555555, 22'h000001},
        {45'h0AAAAAAAAAAA, 22'h3FFFFF},
        {45'h1FFFFFFFFFFF, 22'h000000}
    };

    logic clk = 0, rst_n = 0, sc_pin = 0, line_start = 0, field_start = 0;
    logic [1:0] pin_mode = 2'b10;
    logic [W-1:0] prog_freq = 22'h13579B;
    logic [W-1:0] freq_word;
    logic phase_reset;
    int checks = 0, errors = 0;
    logic [W-1:0] last;
    int seen;

    always #10 clk = ~clk;

    subcarrier_ctl i_subcarrier_ctl (
        .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .sc_pin(sc_pin),
        .line_start(line_start), .field_start(field_start),
        .prog_freq(prog_freq), .freq_word(freq_word), .phase_reset(phase_reset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [NF-1:0] f);
        for (int i = 0; i < 6; i++) begin @(negedge clk); sc_pin = 0; end
        @(negedge clk); sc_pin = 1;
        @(negedge clk); sc_pin = 1;
        for (int k = 0; k < NF; k++) begin
            @(negedge clk); sc_pin = f[k];
            @(negedge clk); sc_pin = f[k];
        end
        @(negedge clk); sc_pin = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_line();
        @(negedge clk); line_start = 1;
        @(negedge clk); line_start = 0;
    endtask

    // Drives one field strobe; returns phase_reset in the cycle after it.
    task automatic pulse_field(output int s);
        @(negedge clk); field_start = 1;
        @(negedge clk); field_start = 0; s = phase_reset;
        @(negedge clk); chk("R7 pulse width", phase_reset, 0);
    endtask

    task automatic rise_pin();
        @(negedge clk); sc_pin = 0;
        @(negedge clk); sc_pin = 1;
        @(negedge clk); sc_pin = 0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pulse", phase_reset, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 word after reset", freq_word, 0);
        chk("R1 pulse after reset", phase_reset, 0);

        last = '0;
        for (int v = 0; v < NV; v++) begin
            send_frame(FRAMES[v]);
            chk("R5 held before line", freq_word, last);
            pulse_line();
            last = FRAMES[v][W-1:0];
            chk("R4 R3 R6 word applied", freq_word, last);
        end
        pulse_line();
        chk("R5 line without frame", freq_word, last);

        pin_mode = 2'b00; @(negedge clk);
        chk("R2 mode 00 word", freq_word, prog_freq);
        pin_mode = 2'b11; prog_freq = 22'h0F0F0F; @(negedge clk);
        chk("R2 mode 11 word", freq_word, prog_freq);
        send_frame({45'h0, 22'h123456});
        rise_pin();
        pulse_field(seen);
        chk("R2 no reset pulse", seen, 0);
        pin_mode = 2'b10; pulse_line();
        chk("R2 frame ignored off", freq_word, last);

        pin_mode = 2'b01; @(negedge clk);
        rise_pin();
        repeat (3) @(negedge clk);
        chk("R7 not immediate", phase_reset, 0);
        pulse_field(seen);
        chk("R7 pulse after field", seen, 1);

        rise_pin(); rise_pin();
        pulse_field(seen);
        chk("R8 first field", seen, 1);
        pulse_field(seen);
        chk("R8 no second reset", seen, 0);

        @(negedge clk); sc_pin = 1; field_start = 1;
        @(negedge clk); field_start = 0; sc_pin = 0;
        chk("R9 not this field", phase_reset, 0);
        pulse_field(seen);
        chk("R9 next field", seen, 1);

        rise_pin();
        pin_mode = 2'b00; @(negedge clk);
        pin_mode = 2'b01; @(negedge clk);
        pulse_field(seen);
        chk("R10 pending dropped", seen, 0);
        pin_mode = 2'b10;
        rise_pin();
        pulse_field(seen);
        chk("R10 none in RTC", seen, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule